// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This block runs on the host side of a parallel NOR flash. After the host has launched an embedded program or erase operation in the device, it pulses `start`. The poller then reads the flash status over a simple request/acknowledge bus toward a flash bus controller. It keeps reading until it can decide whether the operation finished cleanly or failed. It ends with a single-cycle `done` pulse, and `op_pass` or `op_fail` stays asserted until the next start.

The decision rests on a pair of back-to-back reads. The chosen toggle bit (bit 6 by default, bit 2 when `use_bit2` is high) is compared across the pair, and bit 5, the device's error/time-limit flag, is taken from the later read. When the flag is seen while the toggle bit is still moving, the block takes one more read pair before it calls the result. This separates an operation that completed just as the flag rose from a real failure. On a failure or a watchdog expiry, the block writes the reset command 0xF0 so that the device returns to array reads.

The host can park the poller between read pairs with `yield_req`. Polling then resumes from a fresh read pair. `abort` drops the operation without a result.

Top module: `flash_toggle_poller`

## Requirements
- R1: During and after reset, `busy`, `done`, `op_pass`, `op_fail`, `op_timeout` and `bus_req` are all low.
- R2: After `start`, the block issues reads (`bus_we`=0) one at a time. Each read keeps `bus_req`, `bus_we` and `bus_wdata` steady until `bus_ack`.
- R3: If the selected toggle bit has the same value in both reads of a pair, the block ends with `done` and `op_pass` and issues no write.
- R4: `use_bit2`=0 compares data bit 6 and ignores bit 2. `use_bit2`=1 compares data bit 2 and ignores bit 6. The value is captured at `start`.
- R5: If the toggle bit differs within a pair and bit 5 of the second read is 0, the block issues another read pair and applies the same rules to it.
- R6: If the toggle bit differs and bit 5 of the second read is 1, the block issues one recheck pair. If the toggle bit is equal within the recheck pair, the result is pass.
- R7: If the toggle bit still differs within the recheck pair, the block issues one write of 0xF0 (`bus_we`=1). It then ends with `done` and `op_fail`, in the cycle after that write's `bus_ack`.
- R8: If `yield_req` is high when a pair ends toggling with bit 5 low, no request is issued while `yield_req` stays high and `busy` stays high. When `yield_req` drops, polling restarts with a fresh read pair, and no data read before the yield is compared.
- R9: Every completed pair counts toward the watchdog. When a pair that toggles with bit 5 low brings the count to `wd_limit` (a limit of 0 acts as 1), the block writes 0xF0 and ends with `op_fail` and `op_timeout`.
- R10: `abort` while busy returns the block to idle without `done` and without a result. A transaction already issued is completed first. `abort` while idle has no effect.
- R11: `done` is high for exactly one cycle. `op_pass`, `op_fail` and `op_timeout` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin status polling (accepted when idle) |
| abort | input | 1 | Drop the current polling run without a result |
| yield_req | input | 1 | Park between read pairs while high |
| use_bit2 | input | 1 | 0: toggle bit is data bit 6; 1: data bit 2 |
| wd_limit | input | WD_W | Maximum number of read pairs per run |
| bus_req | output | 1 | Transaction request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 8 | Write data (0xF0 reset command) |
| bus_ack | input | 1 | Transaction complete; read data valid |
| bus_rdata | input | 8 | Status data returned by a read |
| busy | output | 1 | A polling run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| op_pass | output | 1 | Run ended with the operation complete |
| op_fail | output | 1 | Run ended with failure or watchdog expiry |
| op_timeout | output | 1 | Failure was caused by the watchdog |

## Verification
The hardest case to reach is the recheck branch. It needs a pair whose toggle bit differs while bit 5 rises in exactly the second read, followed by a recheck pair that either settles or keeps toggling. The bench's flash stub serves a scripted queue of status bytes, so each branch gets an exact read sequence. The yield restart is provoked in a similar way. The pre-yield last read holds a toggle-bit value that would look like toggling against the post-yield data, so resuming mid-sequence would turn the expected pass into extra reads.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  localparam int DATA_W   = 8;
  localparam int ERR_POS  = 5;
  localparam int TGL_HI   = 6;
  localparam int TGL_LO   = 2;
  localparam logic [DATA_W-1:0] RESET_CMD = 8'hF0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD1,
    S_RD2,
    S_SUSP,
    S_RST
  } ftp_state_e;

  // Pick the toggle bit selected by the configuration input.
  function automatic logic tgl_of(input logic [DATA_W-1:0] d, input logic sel2);
    return sel2 ? d[TGL_LO] : d[TGL_HI];
  endfunction

  function automatic logic err_of(input logic [DATA_W-1:0] d);
    return d[ERR_POS];
  endfunction

  // Pair limit reached once the completed count meets the limit (0 acts as 1).
  function automatic logic wd_reached(input int unsigned pairs, input int unsigned limit);
    return pairs >= limit;
  endfunction
endpackage

// File: rtl/ftp_pair_eval.sv
module ftp_pair_eval
  import ftp_pkg::*;
(
  input  logic [DATA_W-1:0] first_rd,
  input  logic [DATA_W-1:0] second_rd,
  input  logic              sel2,
  output logic              toggled,
  output logic              err_flag
);
  always_comb begin
    toggled  = tgl_of(first_rd, sel2) ^ tgl_of(second_rd, sel2);
    err_flag = err_of(second_rd);
  end
endmodule

// File: rtl/ftp_pair_watchdog.sv
module ftp_pair_watchdog
  import ftp_pkg::*;
#(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            pair_evt,
  input  logic [WD_W-1:0] limit,
  output logic            hit
);
  localparam logic [WD_W-1:0] CNT_MAX = '1;

  logic [WD_W-1:0] cnt_q;
  logic [WD_W:0]   cnt_next;

  always_comb begin
    cnt_next = {1'b0, cnt_q} + 1'b1;
    hit      = pair_evt && wd_reached(32'(cnt_next), 32'(limit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clear)                     cnt_q <= '0;
    else if (pair_evt && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // R9: a fresh run starts counting from zero
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0);
  // R9: the count never moves without a pair event or a clear
  p_cnt_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !pair_evt) |=> $stable(cnt_q));
endmodule

// File: rtl/ftp_ctrl.sv
module ftp_ctrl
  import ftp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              yield_req,
  input  logic              use_bit2,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              toggled,
  input  logic              err_flag,
  input  logic              wd_hit,
  output logic              bus_req,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] first_q,
  output logic              sel_q,
  output logic              pair_evt,
  output logic              wd_clear,
  output logic              busy,
  output logic              done,
  output logic              op_pass,
  output logic              op_fail,
  output logic              op_timeout
);
  ftp_state_e state_q;
  logic recheck_q, tmo_pend_q, abort_q, abort_any;

  always_comb begin
    bus_req   = (state_q == S_RD1) || (state_q == S_RD2) || (state_q == S_RST);
    bus_we    = (state_q == S_RST);
    bus_wdata = (state_q == S_RST) ? RESET_CMD : '0;
    busy      = (state_q != S_IDLE);
    pair_evt  = (state_q == S_RD2) && bus_ack;
    wd_clear  = (state_q == S_IDLE) && start;
    abort_any = abort || abort_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      first_q    <= '0;
      sel_q      <= 1'b0;
      recheck_q  <= 1'b0;
      tmo_pend_q <= 1'b0;
      abort_q    <= 1'b0;
      done       <= 1'b0;
      op_pass    <= 1'b0;
      op_fail    <= 1'b0;
      op_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state_q != S_IDLE && abort) abort_q <= 1'b1;
      case (state_q)
        S_IDLE: begin
          abort_q <= 1'b0;
          if (start) begin
            state_q    <= S_RD1;
            sel_q      <= use_bit2;
            recheck_q  <= 1'b0;
            tmo_pend_q <= 1'b0;
            op_pass    <= 1'b0;
            op_fail    <= 1'b0;
            op_timeout <= 1'b0;
          end
        end
        S_RD1: begin
          if (bus_ack) begin
            first_q <= bus_rdata;
            state_q <= abort_any ? S_IDLE : S_RD2;
          end
        end
        S_RD2: begin
          if (bus_ack) begin
            if (abort_any) begin
              state_q <= S_IDLE;
            end else if (!toggled) begin
              state_q <= S_IDLE;
              done    <= 1'b1;
              op_pass <= 1'b1;
            end else if (recheck_q) begin
              state_q <= S_RST;
            end else if (err_flag) begin
              recheck_q <= 1'b1;
              state_q   <= S_RD1;
            end else if (wd_hit) begin
              tmo_pend_q <= 1'b1;
              state_q    <= S_RST;
            end else if (yield_req) begin
              state_q <= S_SUSP;
            end else begin
              state_q <= S_RD1;
            end
          end
        end
        S_SUSP: begin
          if (abort_any)       state_q <= S_IDLE;
          else if (!yield_req) state_q <= S_RD1;
        end
        S_RST: begin
          if (bus_ack) begin
            state_q <= S_IDLE;
            if (!abort_any) begin
              done       <= 1'b1;
              op_fail    <= 1'b1;
              op_timeout <= tmo_pend_q;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2: an issued transaction keeps its request and attributes until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_wdata)));
  // R7: a fail result follows an acknowledged write in the previous cycle
  p_fail_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_fail) |-> $past(bus_req && bus_we && bus_ack));
  // R3: each result is exactly one of pass or fail
  p_one_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({op_pass, op_fail}));
  // R9: a timeout is always reported as a failure
  p_tmo_is_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_timeout) |-> op_fail);
  // R11: done lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: parked means no request while yield is held
  p_park_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SUSP && yield_req && !abort_any) |=> !bus_req);
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import ftp_pkg::*;
#(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic            yield_req,
  input  logic            use_bit2,
  input  logic [WD_W-1:0] wd_limit,
  output logic            bus_req,
  output logic            bus_we,
  output logic [7:0]      bus_wdata,
  input  logic            bus_ack,
  input  logic [7:0]      bus_rdata,
  output logic            busy,
  output logic            done,
  output logic            op_pass,
  output logic            op_fail,
  output logic            op_timeout
);
  // Internal events brought out as named wires
  logic [DATA_W-1:0] first_rd;
  logic              sel_q;
  logic              pair_evt;
  logic              wd_clear;
  logic              pair_toggled;
  logic              pair_err;
  logic              wd_hit;

  ftp_pair_eval u_eval (
    .first_rd (first_rd),
    .second_rd(bus_rdata),
    .sel2     (sel_q),
    .toggled  (pair_toggled),
    .err_flag (pair_err)
  );

  ftp_pair_watchdog #(.WD_W(WD_W)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (wd_clear),
    .pair_evt(pair_evt),
    .limit   (wd_limit),
    .hit     (wd_hit)
  );

  ftp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (abort),
    .yield_req (yield_req),
    .use_bit2  (use_bit2),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .toggled   (pair_toggled),
    .err_flag  (pair_err),
    .wd_hit    (wd_hit),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .first_q   (first_rd),
    .sel_q     (sel_q),
    .pair_evt  (pair_evt),
    .wd_clear  (wd_clear),
    .busy      (busy),
    .done      (done),
    .op_pass   (op_pass),
    .op_fail   (op_fail),
    .op_timeout(op_timeout)
  );

  // R3: a pass result never follows a pair whose toggle bit moved
  p_pass_needs_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_pass) |-> $past(pair_evt && !pair_toggled));
  // R1: no bus activity while idle
  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
endmodule

// File: tb/test_flash_toggle_poller.sv
module test_flash_toggle_poller;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0, abort = 1'b0, yield_req = 1'b0, use_bit2 = 1'b0;
  logic [15:0] wd_limit = 16'd100;
  logic        bus_req, bus_we, bus_ack = 1'b0;
  logic [7:0]  bus_wdata, bus_rdata = 8'h00;
  logic        busy, done, op_pass, op_fail, op_timeout;

  flash_toggle_poller #(.WD_W(16)) i_flash_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .yield_req(yield_req),
    .use_bit2(use_bit2), .wd_limit(wd_limit), .bus_req(bus_req), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy),
    .done(done), .op_pass(op_pass), .op_fail(op_fail), .op_timeout(op_timeout)
  );

  int n_vec = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Flash stub: scripted status bytes, optional free-running toggle on bit 6
  logic [7:0] rdq[$];
  bit   auto_tgl = 0;
  logic auto_v = 1'b0;
  int   lat = 1, wait_c = 0, n_rd = 0, n_wr = 0;
  bit   pend = 0;
  logic pend_we = 1'b0;

  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 1'b0;
      wait_c  = 0;
    end else if (bus_req) begin
      if (pend && bus_we != pend_we) chk(0, "R2 we changed", bus_we, pend_we);
      pend    = 1;
      pend_we = bus_we;
      if (wait_c >= lat) begin
        bus_ack = 1'b1;
        pend    = 0;
        if (bus_we) begin
          n_wr++;
          chk(bus_wdata == 8'hF0, "R7 write data", bus_wdata, 8'hF0);
        end else begin
          n_rd++;
          if (rdq.size() > 0) bus_rdata = rdq.pop_front();
          else if (auto_tgl) begin
            auto_v    = ~auto_v;
            bus_rdata = {1'b0, auto_v, 6'b0};
          end else bus_rdata = 8'h00;
        end
      end else wait_c++;
    end else if (pend) begin
      chk(0, "R2 request dropped before ack", 0, 1);
      pend = 0;
    end
  end

  // Scoreboard
  typedef struct {
    bit    p, f, t;
    int    nrd, nwr;
    string tag;
  } exp_t;
  exp_t expq[$];
  bit   post_chk = 0;
  exp_t last_e;

  always @(negedge clk) begin
    if (post_chk) begin
      post_chk = 0;
      chk(!done, "R11 done longer than one cycle", done, 0);
      chk(op_pass == last_e.p && op_fail == last_e.f && op_timeout == last_e.t,
          "R11 result not held", {op_pass, op_fail, op_timeout},
          {last_e.p, last_e.f, last_e.t});
    end
    if (done) begin
      if (expq.size() == 0) chk(0, "R10 unexpected done", 1, 0);
      else begin
        last_e = expq.pop_front();
        chk(op_pass == last_e.p, {last_e.tag, " pass"}, op_pass, last_e.p);
        chk(op_fail == last_e.f, {last_e.tag, " fail"}, op_fail, last_e.f);
        chk(op_timeout == last_e.t, {last_e.tag, " timeout"}, op_timeout, last_e.t);
        chk(n_rd == last_e.nrd, {last_e.tag, " read count"}, n_rd, last_e.nrd);
        chk(n_wr == last_e.nwr, {last_e.tag, " write count"}, n_wr, last_e.nwr);
        post_chk = 1;
      end
    end
  end

  task automatic launch(input bit p, f, t, input int nrd, nwr, input string tag);
    exp_t e;
    e.p = p; e.f = f; e.t = t; e.nrd = nrd; e.nwr = nwr; e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    while (busy && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(k < 5000, {tag, " run did not end"}, k, 0);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, {tag, " result missing"}, expq.size(), 0);
  endtask

  task automatic push4(input logic [7:0] a, b, c, d);
    rdq.push_back(a); rdq.push_back(b); rdq.push_back(c); rdq.push_back(d);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, done, op_pass, op_fail, op_timeout, bus_req} == 6'b0, "R1 reset outputs",
        {busy, done, op_pass, op_fail, op_timeout, bus_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_req, "R1 idle after reset", busy, 0);

    // R3: stable first pair
    rdq.push_back(8'h00); rdq.push_back(8'h00);
    launch(1, 0, 0, 2, 0, "R3 immediate");
    wait_idle("R3");

    // R5: two toggling pairs, then stable, slow bus
    lat = 3;
    push4(8'h40, 8'h00, 8'h40, 8'h00); rdq.push_back(8'h00); rdq.push_back(8'h00);
    launch(1, 0, 0, 6, 0, "R5 repolling");
    wait_idle("R5");
    lat = 1;

    // R6: error flag rises with toggle, recheck settles
    push4(8'h00, 8'h60, 8'h20, 8'h20);
    launch(1, 0, 0, 4, 0, "R6 late completion");
    wait_idle("R6");

    // R7: recheck still toggling
    push4(8'h00, 8'h60, 8'h20, 8'h60);
    launch(0, 1, 0, 4, 1, "R7 real failure");
    wait_idle("R7");

    // R4: bit 6 selected, bit 2 moving is ignored
    rdq.push_back(8'h04); rdq.push_back(8'h00);
    launch(1, 0, 0, 2, 0, "R4 bit6 ignores bit2");
    wait_idle("R4a");

    // R4: bit 2 selected, bit 6 moving is ignored, then bit 2 toggles once
    use_bit2 = 1'b1;
    push4(8'h04, 8'h00, 8'h40, 8'h00);
    launch(1, 0, 0, 4, 0, "R4 bit2 select");
    wait_idle("R4b");

    // R4 with R7: failure seen on bit 2
    push4(8'h00, 8'h24, 8'h20, 8'h24);
    launch(0, 1, 0, 4, 1, "R4 bit2 failure");
    wait_idle("R4c");
    use_bit2 = 1'b0;

    // R8: yield after a toggling pair, fresh pair afterwards
    yield_req = 1'b1;
    push4(8'h00, 8'h40, 8'h00, 8'h00);
    launch(1, 0, 0, 4, 0, "R8 yield restart");
    for (int k = 0; k < 200 && n_rd < 2; k++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(n_rd == 2 && busy && !bus_req, "R8 parked", n_rd, 2);
    yield_req = 1'b0;
    wait_idle("R8");

    // R9: watchdog after three toggling pairs
    wd_limit = 16'd3; auto_tgl = 1; auto_v = 1'b0;
    launch(0, 1, 1, 6, 1, "R9 watchdog");
    wait_idle("R9");

    // R10: abort while busy, then abort while idle
    wd_limit = 16'd1000; lat = 2;
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    for (int k = 0; k < 50 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req, "R10 idle after abort", busy, 0);
    chk(!op_pass && !op_fail, "R10 no result", {op_pass, op_fail}, 0);
    chk(n_wr == 0, "R10 no reset write", n_wr, 0);
    auto_tgl = 0; lat = 1; wd_limit = 16'd100;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    rdq.push_back(8'h40); rdq.push_back(8'h40);
    launch(1, 0, 0, 2, 0, "R10 idle abort ignored");
    wait_idle("R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule